// File: doc/BRIEF.md
# Cartridge Segment Bank Mapper

This block sits between a CPU with a 20-bit address and the three memories a cartridge system offers: internal RAM, cartridge SRAM and cartridge ROM. The top four address bits pick one of sixteen 64 KB segments. Segment 0 always reaches internal RAM. Segment 1 reaches cartridge SRAM, with the SRAM bank taken from a register. Segments 2 to 15 reach ROM banks. The block drives exactly one memory select together with a wide physical address, which is the bank number placed above the 16-bit offset.

Four byte-wide bank registers sit on a small I/O port. Segments 2 and 3 each have a full 8-bit bank register. Segments 4 to 15 share one base register. The low nibble of that base becomes the high nibble of the bank, and the segment number gives the low nibble. Bank numbers count back from the end of the ROM, so bank 0xFF is always the last 64 KB. A ROM-size input gives the number of valid bank bits. Upper bank bits beyond that count are cleared, so a smaller ROM mirrors and its last bank is still reached by 0xFF.

Reset is asserted asynchronously and released through a synchronizer. Register writes take effect on the clock edge after they are presented. The address decode is combinational from the registers and the CPU address.

Top module: `seg_bank_mapper`

## Requirements
- R1: An address with bits 19:16 equal to 0 asserts ram_sel. phys_addr is then zero in bits 23:16, with bits 15:0 equal to the address offset.
- R2: Segment 1 asserts sram_sel. phys_addr is then {SRAM bank register, offset}.
- R3: Segment 2 asserts rom_sel with bank = the segment-2 register (port 0xC2). Segment 3 uses the segment-3 register (port 0xC3).
- R4: Segments 4 to 15 assert rom_sel with bank bits 7:4 = base register (port 0xC0) bits 3:0 and bank bits 3:0 = the segment number. For example, base 0x4E in segment 9 gives bank 0xE9.
- R5: When rom_sel is asserted, phys_addr = {bank AND mask, offset}. The mask keeps the low rom_bank_bits bits of the bank; any value of 8 or more keeps all 8. Bank 0xFF therefore lands on the last fitted bank.
- R6: After reset the registers read 0x2F (port 0xC0), 0x3F (port 0xC1, SRAM bank), 0xFF (port 0xC2) and 0xFF (port 0xC3).
- R7: A write (io_wr high) to port 0xC0, 0xC1, 0xC2 or 0xC3 updates that register at the clock edge. From the next cycle the new value is read back on io_rdata and used by the mapping.
- R8: Writes to any other port change no register. Reading any other port returns 0x00.
- R9: For every address exactly one of ram_sel, sram_sel and rom_sel is asserted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_wr | input | 1 | I/O write strobe |
| io_addr | input | 8 | I/O port number for write and read |
| io_wdata | input | 8 | I/O write data |
| io_rdata | output | 8 | Register value at io_addr, 0x00 for unmapped ports |
| rom_bank_bits | input | 4 | Number of valid ROM bank bits (0 to 8, larger clamps to 8) |
| cpu_addr | input | 20 | CPU address |
| ram_sel | output | 1 | Internal RAM selected |
| sram_sel | output | 1 | Cartridge SRAM selected |
| rom_sel | output | 1 | Cartridge ROM selected |
| phys_addr | output | 24 | Bank number above the 16-bit offset |

## Verification
The assertions assume that io_addr, io_wdata, io_wr, cpu_addr and rom_bank_bits are stable around the rising edge. They also assume that no write is presented while the reset synchronizer is still releasing. The stimulus changes inputs only just after a rising edge and leaves io_wr low until the synchronized reset has been released. It covers every segment, the mapped and unmapped ports, and several ROM sizes, including zero bank bits and values above eight. A reference model in the bench is compared against the outputs on every falling edge.

// File: rtl/seg_map_pkg.sv
package seg_map_pkg;
  localparam int BANK_W = 8;

  localparam logic [7:0] PORT_BASE = 8'hC0;
  localparam logic [7:0] PORT_SRAM = 8'hC1;
  localparam logic [7:0] PORT_B2   = 8'hC2;
  localparam logic [7:0] PORT_B3   = 8'hC3;

  localparam logic [BANK_W-1:0] RST_BASE = 8'h2F;
  localparam logic [BANK_W-1:0] RST_SRAM = 8'h3F;
  localparam logic [BANK_W-1:0] RST_B2   = 8'hFF;
  localparam logic [BANK_W-1:0] RST_B3   = 8'hFF;

  typedef struct packed {
    logic [BANK_W-1:0] base;
    logic [BANK_W-1:0] sram;
    logic [BANK_W-1:0] b2;
    logic [BANK_W-1:0] b3;
  } bank_regs_t;
endpackage

// File: rtl/segmap_rst_sync.sv
module segmap_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/segmap_regs.sv
module segmap_regs
  import seg_map_pkg::*;
#(
  parameter int IO_AW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              io_wr,
  input  logic [IO_AW-1:0]  io_addr,
  input  logic [BANK_W-1:0] io_wdata,
  output logic [BANK_W-1:0] io_rdata,
  output bank_regs_t        regs
);
  bank_regs_t regs_q;
  bank_regs_t regs_d;
  logic       hit;
  logic       wr_en;

  always_comb begin
    hit = 1'b1;
    case (io_addr)
      IO_AW'(PORT_BASE): io_rdata = regs_q.base;
      IO_AW'(PORT_SRAM): io_rdata = regs_q.sram;
      IO_AW'(PORT_B2):   io_rdata = regs_q.b2;
      IO_AW'(PORT_B3):   io_rdata = regs_q.b3;
      default: begin
        io_rdata = '0;
        hit      = 1'b0;
      end
    endcase
  end

  assign wr_en = io_wr & hit;

  always_comb begin
    regs_d = regs_q;
    case (io_addr)
      IO_AW'(PORT_BASE): regs_d.base = io_wdata;
      IO_AW'(PORT_SRAM): regs_d.sram = io_wdata;
      IO_AW'(PORT_B2):   regs_d.b2   = io_wdata;
      IO_AW'(PORT_B3):   regs_d.b3   = io_wdata;
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      regs_q.base <= RST_BASE;
      regs_q.sram <= RST_SRAM;
      regs_q.b2   <= RST_B2;
      regs_q.b3   <= RST_B3;
    end else if (wr_en) begin
      regs_q <= regs_d;
    end
  end

  assign regs = regs_q;

  // R7
  wr_b2_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr && io_addr == IO_AW'(PORT_B2)) |=> (regs_q.b2 == $past(io_wdata)));

  // R7
  wr_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr && io_addr == IO_AW'(PORT_BASE)) |=> (regs_q.base == $past(io_wdata)));

  // R8
  unmapped_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (io_addr < IO_AW'(PORT_BASE) || io_addr > IO_AW'(PORT_B3)) |=> $stable(regs_q));

  // R8
  unmapped_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (io_addr < IO_AW'(PORT_BASE) || io_addr > IO_AW'(PORT_B3)) |-> (io_rdata == '0));
endmodule

// File: rtl/segmap_decode.sv
module segmap_decode
  import seg_map_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int SEG_W  = 4,
  parameter int SIZE_W = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [ADDR_W-1:0]          cpu_addr,
  input  logic [SIZE_W-1:0]          rom_bank_bits,
  input  bank_regs_t                 regs,
  output logic                       ram_sel,
  output logic                       sram_sel,
  output logic                       rom_sel,
  output logic [BANK_W+ADDR_W-SEG_W-1:0] phys_addr
);
  localparam int OFF_W  = ADDR_W - SEG_W;
  localparam int NSEG   = 1 << SEG_W;
  localparam int PHYS_W = BANK_W + OFF_W;
  localparam int HI_W   = BANK_W - SEG_W;

  logic [SEG_W-1:0]  seg;
  logic [OFF_W-1:0]  off;
  logic [BANK_W-1:0] seg_bank [NSEG];
  logic [BANK_W-1:0] raw_bank;
  logic [BANK_W-1:0] mask;
  logic [BANK_W-1:0] out_bank;

  assign seg = cpu_addr[ADDR_W-1 -: SEG_W];
  assign off = cpu_addr[OFF_W-1:0];

  for (genvar g = 0; g < NSEG; g++) begin : g_seg
    if (g == 0) begin : g_ram
      assign seg_bank[g] = '0;
    end else if (g == 1) begin : g_sram
      assign seg_bank[g] = regs.sram;
    end else if (g == 2) begin : g_b2
      assign seg_bank[g] = regs.b2;
    end else if (g == 3) begin : g_b3
      assign seg_bank[g] = regs.b3;
    end else begin : g_shared
      assign seg_bank[g] = {regs.base[HI_W-1:0], SEG_W'(g)};
    end
  end

  assign raw_bank = seg_bank[seg];

  always_comb begin
    for (int i = 0; i < BANK_W; i++) begin
      mask[i] = (i < int'(rom_bank_bits));
    end
  end

  always_comb begin
    ram_sel  = (seg == SEG_W'(0));
    sram_sel = (seg == SEG_W'(1));
    rom_sel  = !ram_sel && !sram_sel;
    out_bank = rom_sel ? (raw_bank & mask) : raw_bank;
  end

  assign phys_addr = {out_bank, off};

  // R9
  one_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot({ram_sel, sram_sel, rom_sel}));

  // R5
  rom_fold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rom_sel |-> ((phys_addr[PHYS_W-1:OFF_W] & ~mask) == '0));

  // R1
  ram_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ram_sel |-> (phys_addr[PHYS_W-1:OFF_W] == '0 && phys_addr[OFF_W-1:0] == cpu_addr[OFF_W-1:0]));

  // R3
  seg2_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_addr[ADDR_W-1 -: SEG_W] == SEG_W'(2)) |-> (phys_addr[PHYS_W-1:OFF_W] == (regs.b2 & mask)));
endmodule

// File: rtl/seg_bank_mapper.sv
module seg_bank_mapper
  import seg_map_pkg::*;
#(
  parameter int ADDR_W      = 20,
  parameter int SEG_W       = 4,
  parameter int IO_AW       = 8,
  parameter int SIZE_W      = 4,
  parameter int SYNC_STAGES = 2,
  localparam int PHYS_W     = BANK_W + ADDR_W - SEG_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              io_wr,
  input  logic [IO_AW-1:0]  io_addr,
  input  logic [BANK_W-1:0] io_wdata,
  output logic [BANK_W-1:0] io_rdata,
  input  logic [SIZE_W-1:0] rom_bank_bits,
  input  logic [ADDR_W-1:0] cpu_addr,
  output logic              ram_sel,
  output logic              sram_sel,
  output logic              rom_sel,
  output logic [PHYS_W-1:0] phys_addr
);
  logic       rst_sync_n;
  bank_regs_t regs;

  segmap_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  segmap_regs #(.IO_AW(IO_AW)) u_regs (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .io_wr    (io_wr),
    .io_addr  (io_addr),
    .io_wdata (io_wdata),
    .io_rdata (io_rdata),
    .regs     (regs)
  );

  segmap_decode #(.ADDR_W(ADDR_W), .SEG_W(SEG_W), .SIZE_W(SIZE_W)) u_decode (
    .clk           (clk),
    .rst_n         (rst_sync_n),
    .cpu_addr      (cpu_addr),
    .rom_bank_bits (rom_bank_bits),
    .regs          (regs),
    .ram_sel       (ram_sel),
    .sram_sel      (sram_sel),
    .rom_sel       (rom_sel),
    .phys_addr     (phys_addr)
  );
endmodule

// File: tb/seg_bank_mapper_tb.sv
module seg_bank_mapper_tb;
  logic        clk;
  logic        rst_n;
  logic        io_wr;
  logic [7:0]  io_addr;
  logic [7:0]  io_wdata;
  logic [7:0]  io_rdata;
  logic [3:0]  rom_bank_bits;
  logic [19:0] cpu_addr;
  logic        ram_sel, sram_sel, rom_sel;
  logic [23:0] phys_addr;

  int n_checks = 0;
  int n_errors = 0;
  string rd_tag = "R6";
  bit done = 0;

  int m_base, m_sram, m_b2, m_b3;

  seg_bank_mapper u_dut (
    .clk(clk), .rst_n(rst_n), .io_wr(io_wr), .io_addr(io_addr),
    .io_wdata(io_wdata), .io_rdata(io_rdata), .rom_bank_bits(rom_bank_bits),
    .cpu_addr(cpu_addr), .ram_sel(ram_sel), .sram_sel(sram_sel),
    .rom_sel(rom_sel), .phys_addr(phys_addr)
  );

  initial clk = 0;
  always #4 clk = ~clk;

  task automatic chk(input string tag, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // reference model of the register file
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_base <= 'h2F; m_sram <= 'h3F; m_b2 <= 'hFF; m_b3 <= 'hFF;
    end else if (io_wr) begin
      case (io_addr)
        8'hC0: m_base <= io_wdata;
        8'hC1: m_sram <= io_wdata;
        8'hC2: m_b2   <= io_wdata;
        8'hC3: m_b3   <= io_wdata;
        default: ;
      endcase
    end
  end

  function automatic int exp_bank(input int seg);
    int n, mask, b;
    n = (rom_bank_bits > 8) ? 8 : int'(rom_bank_bits);
    mask = (1 << n) - 1;
    case (seg)
      0: return 0;
      1: return m_sram;
      2: b = m_b2;
      3: b = m_b3;
      default: b = (m_base % 16) * 16 + seg;
    endcase
    return b & mask;
  endfunction

  function automatic int exp_rd(input logic [7:0] a);
    case (a)
      8'hC0: return m_base;
      8'hC1: return m_sram;
      8'hC2: return m_b2;
      8'hC3: return m_b3;
      default: return 0;
    endcase
  endfunction

  // compare on every clock, away from the active edge
  always @(negedge clk) begin
    if (!done) begin
      int seg;
      string tag;
      seg = int'(cpu_addr[19:16]);
      case (seg)
        0: tag = "R1";
        1: tag = "R2";
        2, 3: tag = "R3";
        default: tag = "R4";
      endcase
      if (seg >= 2 && rom_bank_bits < 8) tag = "R5";
      chk("R9", int'({ram_sel, sram_sel, rom_sel}),
          (seg == 0) ? 4 : (seg == 1) ? 2 : 1);
      chk(tag, int'(phys_addr), exp_bank(seg) * 65536 + int'(cpu_addr[15:0]));
      chk(rd_tag, int'(io_rdata), exp_rd(io_addr));
    end
  end

  task automatic cyc();
    @(posedge clk); #1;
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    cyc();
    io_wr = 1; io_addr = a; io_wdata = d;
    cyc();
    io_wr = 0;
  endtask

  task automatic sweep(input logic [15:0] off);
    for (int s = 0; s < 16; s++) begin
      cyc();
      cpu_addr = {s[3:0], off ^ 16'(s * 16'h0111)};
    end
  endtask

  task automatic read_ports();
    for (int p = 0; p < 4; p++) begin
      cyc();
      io_addr = 8'hC0 + 8'(p);
    end
  endtask

  initial begin
    #(8 * 20000);
    n_errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    rst_n = 0; io_wr = 0; io_addr = 8'hC0; io_wdata = 0;
    rom_bank_bits = 4'd8; cpu_addr = 20'h0;
    repeat (3) cyc();
    rst_n = 1;
    repeat (4) cyc();

    // R6 reset values
    rd_tag = "R6";
    read_ports();
    sweep(16'h1234);

    // R7 writes, read back and mapping
    rd_tag = "R7";
    wr(8'hC0, 8'h4E);
    wr(8'hC1, 8'h05);
    wr(8'hC2, 8'h12);
    wr(8'hC3, 8'h80);
    read_ports();
    sweep(16'hBEEF);
    cyc();
    cpu_addr = 20'h9ABCD;
    @(negedge clk);
    chk("R4", int'(phys_addr), 'hE9ABCD);

    // R8 unmapped ports
    rd_tag = "R8";
    wr(8'hC4, 8'h00);
    wr(8'hBF, 8'h00);
    wr(8'h10, 8'h00);
    cyc(); io_addr = 8'hC4;
    cyc(); io_addr = 8'h00;
    read_ports();
    cyc();
    cpu_addr = 20'h30010;
    @(negedge clk);
    chk("R8", int'(phys_addr), 'h800010);

    // R5 folding
    rd_tag = "R7";
    wr(8'hC2, 8'hFF);
    rom_bank_bits = 4'd3;
    sweep(16'h0F0F);
    cyc();
    cpu_addr = 20'h20004;
    @(negedge clk);
    chk("R5", int'(phys_addr), 'h070004);
    rom_bank_bits = 4'd0;
    sweep(16'h5555);
    rom_bank_bits = 4'd12;
    sweep(16'hAAAA);
    rom_bank_bits = 4'd6;
    sweep(16'hFFFF);

    // mixed traffic
    rd_tag = "R7";
    for (int i = 0; i < 400; i++) begin
      cyc();
      io_wr = ($urandom % 3) == 0;
      io_addr = 8'hBE + 8'($urandom % 8);
      io_wdata = 8'($urandom);
      cpu_addr = 20'($urandom);
      rom_bank_bits = 4'($urandom);
    end
    cyc();
    io_wr = 0;
    cyc();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule